// File: doc/BRIEF.md
# Skid-Buffered Pipeline Stage

This block is one registered stage between an upstream producer and a downstream consumer. Each side uses a strobe/busy handshake. An incoming word goes through a fixed combinational transform, which adds a parameterised step modulo 2^DATA_W. The result is then registered and offered downstream one clock later. When the consumer keeps the stage from moving on, one clock's worth of data is already in flight. The producer cannot take that word back.

That word is therefore always taken into a second register, the skid register, on the edge where the block occurs. The busy flag towards the producer rises from that same edge onwards. When the consumer frees up, the skid word leaves first and the busy flag drops again. The output register picks its next value from either the skid register or the freshly transformed input, according to that stall flag. With a free consumer the stage moves one word per clock without bubbles.

Top module: `skid_pipe_stage`

## Requirements
- R1: A word is taken from upstream on a rising edge only when `up_valid` is 1 and `up_busy` is 0 during the preceding cycle; at all other times `up_data` has no effect.
- R2: A word leaves downstream on a rising edge only when `dn_valid` is 1 and `dn_busy` is 0 during the preceding cycle.
- R3: A word accepted into an empty stage appears on `dn_valid`/`dn_data` right after the accepting edge (one clock of latency).
- R4: With `dn_busy` held at 0 and `up_valid` held at 1, a word is accepted and emitted on every clock: N consecutive accepts from empty yield N-1 transfers over those N cycles.
- R5: If a word is accepted while the output holds an untransferred word and `dn_busy` is 1, that word is stored in the skid register. `up_busy` reads 1 from the following edge until the skid register is released.
- R6: When the consumer frees up with the skid register full, the output register is loaded from the skid register before any new input. `up_busy` returns to 0 after that edge.
- R7: `dn_valid` stays 1 as long as any accepted word has not yet been transferred, and falls only once all of them have left.
- R8: While `dn_valid` is 1 and `dn_busy` is 1, `dn_valid` and `dn_data` hold their values on the next clock.
- R9: The emitted word equals the accepted word plus STEP (default 1), wrapped modulo 2^DATA_W.
- R10: A synchronous active-high `rst` forces `dn_valid` and `up_busy` to 0.
- R11: The sequence of emitted words equals the sequence of transformed accepted words, with no loss, duplication or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Producer offers a word |
| up_data | input | DATA_W | Word from the producer |
| up_busy | output | 1 | Stage refuses new words (stall flag) |
| dn_valid | output | 1 | Stage offers a word to the consumer |
| dn_data | output | DATA_W | Transformed word to the consumer |
| dn_busy | input | 1 | Consumer cannot take a word this cycle |

## Verification
The bench builds the stage with DATA_W set to 8 and STEP left at 1. At that width, random input words regularly hit 255, so the wrap of the transform (R9) comes up in ordinary traffic. The narrow word also keeps the reference queue compact. Random strobe and busy patterns often produce back-to-back block and release cycles. In those cycles the skid register fills and drains repeatedly, and the ordering checks against the model see it happen.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;

    // Source of the next word loaded into the output register
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_INPUT = 2'd1,
        SRC_SKID  = 2'd2
    } src_sel_e;

    // Output register may take a new value when empty or being drained
    function automatic logic out_can_load(input logic vld, input logic busy);
        return !vld || !busy;
    endfunction

    // Pick the output source from stall state and upstream acceptance
    function automatic src_sel_e pick_source(input logic can_load,
                                             input logic stalled,
                                             input logic taken);
        if (!can_load)   return SRC_IDLE;
        else if (stalled) return SRC_SKID;
        else if (taken)   return SRC_INPUT;
        else              return SRC_IDLE;
    endfunction

endpackage

// File: rtl/pipe_proc.sv
module pipe_proc #(
    parameter int DATA_W = 16,
    parameter int STEP   = 1
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STEP);

    always_comb begin
        dout = din + STEP_W;
    end
endmodule

// File: rtl/pipe_skid.sv
module pipe_skid #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              drain,
    input  logic [DATA_W-1:0] din,
    output logic              stalled,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stalled <= 1'b0;
        end else if (capture) begin
            stalled <= 1'b1;
        end else if (drain) begin
            stalled <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (capture) begin
            held <= din;
        end
    end
endmodule

// File: rtl/pipe_outreg.sv
module pipe_outreg
    import pipe_stage_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] fresh,
    input  logic [DATA_W-1:0] skid,
    output logic              vld,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
        end else if (load) begin
            vld <= (sel != SRC_IDLE);
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            unique case (sel)
                SRC_SKID:  data <= skid;
                SRC_INPUT: data <= fresh;
                default:   data <= data;
            endcase
        end
    end
endmodule

// File: rtl/skid_pipe_stage.sv
module skid_pipe_stage
    import pipe_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_busy,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_busy
);
    logic [DATA_W-1:0] proc_word;
    logic [DATA_W-1:0] skid_word;
    logic              stalled;
    logic              can_load;
    logic              taken;
    logic              capture;
    src_sel_e          sel;

    pipe_proc #(.DATA_W(DATA_W), .STEP(STEP)) i_proc (
        .din  (up_data),
        .dout (proc_word)
    );

    always_comb begin
        can_load = out_can_load(dn_valid, dn_busy);
        taken    = up_valid && !stalled;
        capture  = taken && !can_load;
        sel      = pick_source(can_load, stalled, taken);
    end

    pipe_skid #(.DATA_W(DATA_W)) i_skid (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .drain   (can_load),
        .din     (proc_word),
        .stalled (stalled),
        .held    (skid_word)
    );

    pipe_outreg #(.DATA_W(DATA_W)) i_out (
        .clk   (clk),
        .rst   (rst),
        .load  (can_load),
        .sel   (sel),
        .fresh (proc_word),
        .skid  (skid_word),
        .vld   (dn_valid),
        .data  (dn_data)
    );

    assign up_busy = stalled;
endmodule

// File: rtl/skid_pipe_stage_chk.sv
module skid_pipe_stage_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_busy,
    input logic              dn_valid,
    input logic [DATA_W-1:0] dn_data,
    input logic              dn_busy
);
    logic was_rst = 1'b0;
    always_ff @(posedge clk) was_rst <= rst;

    AST_RESET_CLEARS: assert property (@(posedge clk) was_rst |-> (!dn_valid && !up_busy)); // R10

    AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_busy) |=> (dn_valid && $stable(dn_data))); // R8

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_busy) |=> dn_valid); // R3

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(up_busy) |-> $past(up_valid && dn_valid && dn_busy)); // R5

    AST_STALL_HAS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        up_busy |-> dn_valid); // R7

    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (up_busy && !dn_busy) |=> (!up_busy && dn_valid)); // R6
endmodule

bind skid_pipe_stage skid_pipe_stage_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_busy  (up_busy),
    .dn_valid (dn_valid),
    .dn_data  (dn_data),
    .dn_busy  (dn_busy)
);

// File: tb/test_skid_pipe_stage.sv
module test_skid_pipe_stage;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up_valid = 1'b0;
    logic [W-1:0] up_data = '0;
    logic         up_busy;
    logic         dn_valid;
    logic [W-1:0] dn_data;
    logic         dn_busy = 1'b0;

    int checks = 0;
    int fails  = 0;
    int xfers  = 0;
    logic [W-1:0] exp_q[$];

    always #2 clk = ~clk;

    skid_pipe_stage #(.DATA_W(W), .STEP(1)) i_skid_pipe_stage (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_data(up_data),
        .up_busy(up_busy), .dn_valid(dn_valid), .dn_data(dn_data), .dn_busy(dn_busy)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs with model, drive inputs, advance model
    task automatic step(input logic uv, input logic [W-1:0] ud, input logic db);
        @(negedge clk);
        check(dn_valid == (exp_q.size() > 0), "R3 R7 dn_valid", int'(dn_valid), int'(exp_q.size() > 0));
        check(up_busy == (exp_q.size() == 2), "R5 R6 up_busy", int'(up_busy), int'(exp_q.size() == 2));
        if (exp_q.size() > 0)
            check(dn_data == exp_q[0], "R6 R8 R9 R11 dn_data", int'(dn_data), int'(exp_q[0]));
        up_valid = uv;
        up_data  = ud;
        dn_busy  = db;
        // R2: transfer only when offered and consumer free
        if (dn_valid && !db) begin
            void'(exp_q.pop_front());
            xfers++;
        end
        // R1: acceptance only when strobe high and not busy
        if (uv && !up_busy) exp_q.push_back(ud + W'(1));
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!dn_valid, "R10 dn_valid after reset", int'(dn_valid), 0);
        check(!up_busy, "R10 up_busy after reset", int'(up_busy), 0);

        // R4: full throughput with a free consumer
        xfers = 0;
        for (int i = 0; i < 20; i++) step(1'b1, W'(i * 13 + 250), 1'b0);
        check(xfers == 19, "R4 transfers in 20 cycles", xfers, 19);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0);
        check(!dn_valid, "R7 empty after drain", int'(dn_valid), 0);

        // Directed block/release: skid fills, busy rises, drain in order
        step(1'b0, '0, 1'b1);
        step(1'b1, 8'd5, 1'b0);
        step(1'b1, 8'd7, 1'b0);
        step(1'b1, 8'd2, 1'b1);
        step(1'b1, 8'd9, 1'b1);
        step(1'b0, 8'd12, 1'b1);
        check(up_busy, "R5 busy while skid full", int'(up_busy), 1);
        step(1'b0, 8'd32, 1'b0);
        step(1'b0, 8'd32, 1'b0);
        check(dn_valid, "R7 still holding word", int'(dn_valid), 1);
        step(1'b0, 8'd32, 1'b0);
        step(1'b0, 8'd32, 1'b0);
        check(!dn_valid, "R7 strobe falls after last word", int'(dn_valid), 0);

        // Ignored data while busy: 255 offered during stall never appears
        step(1'b1, 8'd100, 1'b1);
        step(1'b1, 8'd101, 1'b1);
        step(1'b1, 8'd255, 1'b1);
        step(1'b1, 8'd254, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
        check(exp_q.size() == 0, "R1 R11 model drained", exp_q.size(), 0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            step(1'(($urandom % 4) != 0), W'($urandom), 1'(($urandom % 3) == 0));
        end
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
        check(exp_q.size() == 0 && !dn_valid, "R11 all words delivered", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule